// File: doc/BRIEF.md
# Adjustable Hardware Time Counter with Target Pulse

This block keeps device time as two fields: a nanosecond-scale fraction that wraps at a parameterised count per second (10^9 by default) and a 32-bit seconds field that takes the carry. With no correction, the fraction advances by one count per clock.

Software drives a one-cycle operation strobe with a code. One code schedules a new seconds value. It is loaded at the next second boundary, not at once. Another code stores a signed frequency trim in clock counts. At every boundary the trim is reloaded and then worked off one count per clock. A positive trim adds a count on each of those clocks, so the second is shorter. A negative trim holds the fraction still for those clocks, so the second is longer. The whole trim is used up before the boundary is reached.

A compare unit holds one 64-bit target time, with the seconds in the upper half and the fraction in the lower half. When an enabled target with a valid mode is written, the unit is armed. It raises a one-clock pulse, on a physical output, on a virtual output, or on both, the first time the counter reaches or passes the target. It then stays quiet until a new target is written.

Top module: `tc_hw_clock`

## Requirements
- R1: While reset is applied and right after it, time_sec and time_ns read 0 and both pulse outputs are low.
- R2: With zero trim, time_ns rises by exactly 1 per clock. After NS_PER_SEC-1 it wraps to 0, and in that same cycle time_sec rises by 1, so one second lasts NS_PER_SEC clocks.
- R3: op_code 0 with op_valid records op_sec. time_sec does not change before the next boundary. At that boundary time_sec takes the recorded value, and the latest request before the boundary wins. The request is then consumed, so the following boundary adds 1 again.
- R4: op_code 3 with op_valid stores op_freq as a signed trim k. The second that is running when the write happens keeps its length. Every second that starts at a later boundary lasts NS_PER_SEC-k clocks for 0 < k.
- R5: A negative trim k makes each second that starts at a later boundary last NS_PER_SEC+|k| clocks.
- R6: The trim magnitude is limited to (NS_PER_SEC-1)/2 (integer division). Larger values act as that limit with the same sign. time_ns always stays below NS_PER_SEC.
- R7: Any op_code other than 0 and 3 changes nothing: the second length and the next boundary's seconds value stay as they were.
- R8: tgt_wr with tgt_en=1 and a tgt_mode of 1 (physical), 2 (virtual) or 3 (both) arms the target. The target is compared as {seconds, fraction}. A pulse appears on pps_pulse when mode bit 0 is set and on virt_pulse when mode bit 1 is set. The pulse lasts one clock, in the cycle after the first cycle whose time is equal to or later than the target.
- R9: A target that is already reached or passed when it is written fires in the second cycle after the write cycle.
- R10: tgt_en=0, tgt_mode 0, or any tgt_mode of 4 and above leaves the unit disarmed with no pulse. Such a write also cancels a pending armed target.
- R11: After firing, the unit produces no further pulse until the target is written again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_valid | input | 1 | One-cycle operation strobe |
| op_code | input | 4 | Operation code: 0 set seconds at next boundary, 3 frequency trim |
| op_sec | input | 32 | Seconds value for code 0 |
| op_freq | input | 32 | Signed trim in clock counts for code 3 |
| tgt_wr | input | 1 | Target write strobe |
| tgt_time | input | 64 | Target time, seconds in [63:32], fraction in [31:0] |
| tgt_mode | input | 4 | Output selection: 1 physical, 2 virtual, 3 both |
| tgt_en | input | 1 | Target enable |
| time_sec | output | 32 | Current seconds |
| time_ns | output | 32 | Current fraction of a second |
| pps_pulse | output | 1 | One-clock physical target pulse |
| virt_pulse | output | 1 | One-clock virtual target pulse |

## Verification
If the trim counter were left non-zero or decoded with the wrong sign, the damage would show at the very next boundary: the second would be shorter or longer than NS_PER_SEC minus the clamped trim. A pending seconds flag that is never cleared would show one boundary later, because time_sec would freeze at the loaded value instead of rising by 1. A stuck armed flag, or a compare against stale target bits, would show within a single compare window as a missing, early, late or repeated pulse on either output. Sweeping every trim value through and beyond the clamp, and every target offset around the current time for each mode, exposes these faults.

// File: rtl/tc_pkg.sv
`timescale 1ns/1ps
package tc_pkg;
  localparam int TC_OPC_W  = 4;
  localparam int TC_MODE_W = 4;

  localparam logic [TC_OPC_W-1:0] OPC_SET_SEC   = 4'd0;
  localparam logic [TC_OPC_W-1:0] OPC_FREQ_TRIM = 4'd3;

  localparam logic [TC_MODE_W-1:0] PM_PHYS = 4'd1;
  localparam logic [TC_MODE_W-1:0] PM_VIRT = 4'd2;
  localparam logic [TC_MODE_W-1:0] PM_BOTH = 4'd3;

  typedef struct packed {
    logic virt;
    logic phys;
  } route_t;
endpackage

// File: rtl/tc_op_decode.sv
`timescale 1ns/1ps
module tc_op_decode
  import tc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int ADJ_W = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    op_valid_i,
  input  logic [TC_OPC_W-1:0]     op_code_i,
  input  logic [SEC_W-1:0]        op_sec_i,
  input  logic [ADJ_W-1:0]        op_freq_i,
  input  logic                    boundary_i,
  output logic                    pend_o,
  output logic [SEC_W-1:0]        pend_sec_o,
  output logic signed [ADJ_W-1:0] adj_o
);
  logic                    set_req, trim_req;
  logic                    pend_d, pend_q;
  logic [SEC_W-1:0]        pend_sec_q;
  logic signed [ADJ_W-1:0] adj_q;

  always_comb begin
    set_req  = op_valid_i && (op_code_i == OPC_SET_SEC);
    trim_req = op_valid_i && (op_code_i == OPC_FREQ_TRIM);
    if (set_req)         pend_d = 1'b1;
    else if (boundary_i) pend_d = 1'b0;
    else                 pend_d = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      pend_sec_q <= '0;
      adj_q      <= '0;
    end else begin
      pend_q <= pend_d;
      if (set_req)  pend_sec_q <= op_sec_i;
      if (trim_req) adj_q      <= $signed(op_freq_i);
    end
  end

  assign pend_o     = pend_q;
  assign pend_sec_o = pend_sec_q;
  assign adj_o      = adj_q;

  // R3: a boundary without a fresh request consumes the pending load
  a_r3_pend_consumed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary_i && !set_req |=> !pend_q);

  // R3: a request always leaves a pending load behind
  a_r3_pend_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_req |=> pend_q && (pend_sec_q == $past(op_sec_i)));

  // R7: unknown codes touch no stored state
  a_r7_unknown_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_valid_i && (op_code_i != OPC_SET_SEC) && (op_code_i != OPC_FREQ_TRIM) && !boundary_i
    |=> $stable(pend_q) && $stable(pend_sec_q) && $stable(adj_q));
endmodule

// File: rtl/tc_time_core.sv
`timescale 1ns/1ps
module tc_time_core #(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int          SEC_W      = 32,
  parameter int          NS_W       = 32,
  parameter int          ADJ_W      = 32
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic signed [ADJ_W-1:0] adj_i,
  input  logic                    pend_i,
  input  logic [SEC_W-1:0]        pend_sec_i,
  output logic [SEC_W-1:0]        sec_o,
  output logic [NS_W-1:0]         ns_o,
  output logic                    boundary_o
);
  localparam logic [NS_W-1:0]         NS_LIM   = NS_W'(NS_PER_SEC);
  localparam logic signed [ADJ_W-1:0] TRIM_LIM = ADJ_W'((NS_PER_SEC - 1) / 2);

  logic [NS_W-1:0]         ns_q, ns_d, ns_sum;
  logic [SEC_W-1:0]        sec_q, sec_d;
  logic signed [ADJ_W-1:0] trim_q, trim_d;
  logic [1:0]              step;
  logic                    boundary;

  function automatic logic signed [ADJ_W-1:0] clamp_trim(input logic signed [ADJ_W-1:0] a);
    if (a > TRIM_LIM)       return TRIM_LIM;
    else if (a < -TRIM_LIM) return -TRIM_LIM;
    else                    return a;
  endfunction

  always_comb begin
    if (trim_q > 0)      step = 2'd2;
    else if (trim_q < 0) step = 2'd0;
    else                 step = 2'd1;

    ns_sum   = ns_q + NS_W'(step);
    boundary = (ns_sum >= NS_LIM);
    ns_d     = boundary ? (ns_sum - NS_LIM) : ns_sum;

    if (boundary) sec_d = pend_i ? pend_sec_i : (sec_q + SEC_W'(1));
    else          sec_d = sec_q;

    if (boundary)        trim_d = clamp_trim(adj_i);
    else if (trim_q > 0) trim_d = trim_q - ADJ_W'(1);
    else if (trim_q < 0) trim_d = trim_q + ADJ_W'(1);
    else                 trim_d = trim_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ns_q   <= '0;
      sec_q  <= '0;
      trim_q <= '0;
    end else begin
      ns_q   <= ns_d;
      trim_q <= trim_d;
      if (boundary) sec_q <= sec_d;
    end
  end

  assign sec_o      = sec_q;
  assign ns_o       = ns_q;
  assign boundary_o = boundary;

  // R6: the fraction never reaches the per-second limit
  a_r6_ns_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ns_q < NS_LIM);

  // R6: the remaining trim stays inside the clamp
  a_r6_trim_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_q <= TRIM_LIM) && (trim_q >= -TRIM_LIM));

  // R2: seconds only move at a boundary
  a_r2_sec_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary |=> $stable(sec_q));

  // R4: inside a second the fraction moves forward by at most two counts
  a_r4_step_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !boundary |=> (ns_q >= $past(ns_q)) && ((ns_q - $past(ns_q)) <= NS_W'(2)));

  // R3: a pending load lands on the seconds field at the boundary
  a_r3_load_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boundary && pend_i |=> sec_q == $past(pend_sec_i));
endmodule

// File: rtl/tc_target_cmp.sv
`timescale 1ns/1ps
module tc_target_cmp
  import tc_pkg::*;
#(
  parameter int SEC_W = 32,
  parameter int NS_W  = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   tgt_wr_i,
  input  logic [SEC_W+NS_W-1:0]  tgt_time_i,
  input  logic [TC_MODE_W-1:0]   tgt_mode_i,
  input  logic                   tgt_en_i,
  input  logic [SEC_W-1:0]       now_sec_i,
  input  logic [NS_W-1:0]        now_ns_i,
  output logic                   pps_o,
  output logic                   virt_o
);
  localparam int TS_W = SEC_W + NS_W;

  logic [TS_W-1:0] tgt_q, now;
  route_t          route_q, route_d;
  logic            armed_q, armed_d, mode_ok, hit;
  logic            pps_q, virt_q, pps_d, virt_d;

  always_comb begin
    now     = {now_sec_i, now_ns_i};
    mode_ok = (tgt_mode_i == PM_PHYS) || (tgt_mode_i == PM_VIRT) || (tgt_mode_i == PM_BOTH);
    route_d = route_t'(tgt_mode_i[1:0]);
    // a write in the same cycle takes priority over firing
    hit     = armed_q && !tgt_wr_i && (now >= tgt_q);
    if (tgt_wr_i) armed_d = tgt_en_i && mode_ok;
    else if (hit) armed_d = 1'b0;
    else          armed_d = armed_q;
    pps_d  = hit && route_q.phys;
    virt_d = hit && route_q.virt;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q   <= '0;
      route_q <= '0;
      armed_q <= 1'b0;
      pps_q   <= 1'b0;
      virt_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      pps_q   <= pps_d;
      virt_q  <= virt_d;
      if (tgt_wr_i) begin
        tgt_q   <= tgt_time_i;
        route_q <= route_d;
      end
    end
  end

  assign pps_o  = pps_q;
  assign virt_o = virt_q;

  // R11: a pulse never lasts two cycles
  a_r11_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pps_q || virt_q) |=> !(pps_q || virt_q));

  // R10: no pulse follows a disarmed cycle
  a_r10_quiet_unarmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !armed_q |=> !pps_q && !virt_q);

  // R8: an armed, due target produces a pulse and disarms
  a_r8_due_fires: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q && !tgt_wr_i && (now >= tgt_q) |=> (pps_q || virt_q) && !armed_q);

  // R10: a disabled write leaves the unit disarmed
  a_r10_disabled_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tgt_wr_i && !tgt_en_i |=> !armed_q);
endmodule

// File: rtl/tc_hw_clock.sv
`timescale 1ns/1ps
module tc_hw_clock
  import tc_pkg::*;
#(
  parameter int unsigned NS_PER_SEC = 1_000_000_000,
  parameter int          SEC_W      = 32,
  parameter int          NS_W       = 32,
  parameter int          ADJ_W      = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic [3:0]            op_code,
  input  logic [SEC_W-1:0]      op_sec,
  input  logic [ADJ_W-1:0]      op_freq,
  input  logic                  tgt_wr,
  input  logic [SEC_W+NS_W-1:0] tgt_time,
  input  logic [3:0]            tgt_mode,
  input  logic                  tgt_en,
  output logic [SEC_W-1:0]      time_sec,
  output logic [NS_W-1:0]       time_ns,
  output logic                  pps_pulse,
  output logic                  virt_pulse
);
  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    boundary, pend;
  logic [SEC_W-1:0]        pend_sec;
  logic signed [ADJ_W-1:0] adj;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  tc_op_decode #(.SEC_W(SEC_W), .ADJ_W(ADJ_W)) u_dec (
    .clk_i      (clk),
    .rst_ni     (rst_int_n),
    .op_valid_i (op_valid),
    .op_code_i  (op_code),
    .op_sec_i   (op_sec),
    .op_freq_i  (op_freq),
    .boundary_i (boundary),
    .pend_o     (pend),
    .pend_sec_o (pend_sec),
    .adj_o      (adj)
  );

  tc_time_core #(.NS_PER_SEC(NS_PER_SEC), .SEC_W(SEC_W), .NS_W(NS_W), .ADJ_W(ADJ_W)) u_core (
    .clk_i      (clk),
    .rst_ni     (rst_int_n),
    .adj_i      (adj),
    .pend_i     (pend),
    .pend_sec_i (pend_sec),
    .sec_o      (time_sec),
    .ns_o       (time_ns),
    .boundary_o (boundary)
  );

  tc_target_cmp #(.SEC_W(SEC_W), .NS_W(NS_W)) u_cmp (
    .clk_i      (clk),
    .rst_ni     (rst_int_n),
    .tgt_wr_i   (tgt_wr),
    .tgt_time_i (tgt_time),
    .tgt_mode_i (tgt_mode),
    .tgt_en_i   (tgt_en),
    .now_sec_i  (time_sec),
    .now_ns_i   (time_ns),
    .pps_o      (pps_pulse),
    .virt_o     (virt_pulse)
  );
endmodule

// File: tb/tb_tc_hw_clock.sv
`timescale 1ns/1ps
module tb_tc_hw_clock;
  localparam int BNS = 100;
  localparam int LIM = (BNS - 1) / 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [31:0] op_sec, op_freq;
  logic        tgt_wr;
  logic [63:0] tgt_time;
  logic [3:0]  tgt_mode;
  logic        tgt_en;
  logic [31:0] time_sec, time_ns;
  logic        pps_pulse, virt_pulse;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  tc_hw_clock #(.NS_PER_SEC(BNS)) dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_sec(op_sec), .op_freq(op_freq), .tgt_wr(tgt_wr), .tgt_time(tgt_time),
    .tgt_mode(tgt_mode), .tgt_en(tgt_en), .time_sec(time_sec), .time_ns(time_ns),
    .pps_pulse(pps_pulse), .virt_pulse(virt_pulse)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic do_op(input logic [3:0] code, input logic [31:0] s, input logic [31:0] f);
    op_valid = 1'b1; op_code = code; op_sec = s; op_freq = f;
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic wait_boundary();
    logic [31:0] s0;
    s0 = time_sec;
    do @(negedge clk); while (time_sec == s0);
  endtask

  task automatic measure(output int len);
    logic [31:0] s0;
    wait_boundary();
    s0  = time_sec;
    len = 0;
    do begin @(negedge clk); len++; end while (time_sec == s0);
  endtask

  function automatic int clampk(input int k);
    if (k > LIM)  return LIM;
    if (k < -LIM) return -LIM;
    return k;
  endfunction

  task automatic run_tgt(input int off, input logic [3:0] mode, input bit en, input string req);
    longint t0, tt;
    int fire_j, mis_p, mis_v, cnt_p, cnt_v, exp_cnt;
    bit live, ep, ev;
    mis_p = 0; mis_v = 0; cnt_p = 0; cnt_v = 0;
    t0 = longint'(time_sec) * BNS + longint'(time_ns);
    tt = t0 + off;
    tgt_time = {32'(tt / BNS), 32'(tt % BNS)};
    tgt_mode = mode; tgt_en = en; tgt_wr = 1'b1;
    @(negedge clk);
    tgt_wr = 1'b0;
    live   = en && (mode >= 4'd1) && (mode <= 4'd3);
    fire_j = ((off > 1) ? off : 1) + 1;
    if (pps_pulse || virt_pulse) mis_p++;
    for (int j = 2; j <= 50; j++) begin
      @(negedge clk);
      ep = live && (j == fire_j) && mode[0];
      ev = live && (j == fire_j) && mode[1];
      if (pps_pulse != ep)  mis_p++;
      if (virt_pulse != ev) mis_v++;
      cnt_p += int'(pps_pulse);
      cnt_v += int'(virt_pulse);
    end
    chk(mis_p == 0, req, $sformatf("pps timing off=%0d mode=%0d en=%0d", off, mode, en), mis_p, 0);
    chk(mis_v == 0, req, $sformatf("virt timing off=%0d mode=%0d en=%0d", off, mode, en), mis_v, 0);
    exp_cnt = (live && mode[0]) ? 1 : 0;
    chk(cnt_p == exp_cnt, "R11", "pps pulse count", cnt_p, exp_cnt);
    exp_cnt = (live && mode[1]) ? 1 : 0;
    chk(cnt_v == exp_cnt, "R11", "virt pulse count", cnt_v, exp_cnt);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int len, mx, cnt;
    logic [31:0] s0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; op_sec = '0; op_freq = '0;
    tgt_wr = 1'b0; tgt_time = '0; tgt_mode = '0; tgt_en = 1'b0;
    repeat (4) @(negedge clk);
    // R1: held in reset
    chk(time_sec == 0 && time_ns == 0, "R1", "time in reset", time_ns, 0);
    chk(!pps_pulse && !virt_pulse, "R1", "pulses in reset", pps_pulse, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(time_sec == 0, "R1", "sec after release", time_sec, 0);
    chk(!pps_pulse && !virt_pulse, "R1", "pulses after release", virt_pulse, 0);

    // R2: plain counting, wrap and carry
    wait_boundary();
    chk(time_sec == 1 && time_ns == 0, "R2", "first carry", time_ns, 0);
    mx = 0; cnt = 0; s0 = time_sec;
    do begin
      @(negedge clk);
      if (time_sec == s0) begin
        if (int'(time_ns) > mx) mx = int'(time_ns);
        if (int'(time_ns) != cnt + 1) cnt = -1000; else cnt++;
      end
    end while (time_sec == s0);
    chk(cnt == BNS - 1, "R2", "unit step count", cnt, BNS - 1);
    chk(mx == BNS - 1, "R2", "highest fraction", mx, BNS - 1);
    chk(time_sec == s0 + 1, "R2", "sec increment", time_sec, s0 + 1);
    measure(len);
    chk(len == BNS, "R2", "second length", len, BNS);

    // R4: a write does not change the second in progress
    wait_boundary();
    s0 = time_sec; cnt = 0;
    do_op(4'd3, 32'd0, 32'd20); cnt = 1;
    while (time_sec == s0) begin @(negedge clk); cnt++; end
    chk(cnt == BNS, "R4", "current second untouched", cnt, BNS);
    measure(len);
    chk(len == BNS - 20, "R4", "trimmed second", len, BNS - 20);

    // R4 R5 R6: sweep of trims through and past the clamp
    for (int k = -60; k <= 60; k++) begin
      wait_boundary();
      do_op(4'd3, 32'd0, 32'(k));
      measure(len);
      chk(len == BNS - clampk(k), (k > 0) ? ((k > LIM) ? "R6" : "R4") : ((k < -LIM) ? "R6" : "R5"),
          $sformatf("second length trim=%0d", k), len, BNS - clampk(k));
    end

    // R7: unknown codes change nothing
    wait_boundary();
    do_op(4'd3, 32'd0, 32'd5);
    wait_boundary();
    for (int c = 1; c < 16; c++) begin
      if (c != 3) do_op(4'(c), 32'd777, 32'd30);
    end
    s0 = time_sec;
    wait_boundary();
    chk(time_sec == s0 + 1, "R7", "sec after unknown codes", time_sec, s0 + 1);
    measure(len);
    chk(len == BNS - 5, "R7", "length after unknown codes", len, BNS - 5);

    // R3: set seconds at next boundary
    do_op(4'd3, 32'd0, 32'd0);
    wait_boundary();
    wait_boundary();
    s0 = time_sec;
    do_op(4'd0, 32'd5000, 32'd0);
    chk(time_sec == s0, "R3", "no immediate load", time_sec, s0);
    wait_boundary();
    chk(time_sec == 32'd5000 && time_ns == 0, "R3", "loaded at boundary", time_sec, 5000);
    do_op(4'd0, 32'd9000, 32'd0);
    do_op(4'd0, 32'd9100, 32'd0);
    wait_boundary();
    chk(time_sec == 32'd9100, "R3", "latest request wins", time_sec, 9100);
    wait_boundary();
    chk(time_sec == 32'd9101, "R3", "request consumed", time_sec, 9101);

    // R8 R9: target sweep for each output mode
    for (int m = 1; m <= 3; m++) begin
      for (int off = -3; off <= 40; off++) begin
        run_tgt(off, 4'(m), 1'b1, (off <= 0) ? "R9" : "R8");
      end
    end

    // R10: disabled and invalid modes
    run_tgt(10, 4'd3, 1'b0, "R10");
    run_tgt(10, 4'd0, 1'b1, "R10");
    run_tgt(10, 4'd7, 1'b1, "R10");
    run_tgt(-2, 4'd4, 1'b1, "R10");

    // R10: a disabled write cancels a pending target
    tgt_time = {time_sec, time_ns} + 64'd20;
    tgt_mode = 4'd3; tgt_en = 1'b1; tgt_wr = 1'b1;
    @(negedge clk);
    tgt_en = 1'b0;
    @(negedge clk);
    tgt_wr = 1'b0;
    cnt = 0;
    for (int j = 0; j < 60; j++) begin
      @(negedge clk);
      cnt += int'(pps_pulse) + int'(virt_pulse);
    end
    chk(cnt == 0, "R10", "cancelled target", cnt, 0);

    // R11: rearming after a fire works again
    run_tgt(5, 4'd3, 1'b1, "R11");
    run_tgt(5, 4'd1, 1'b1, "R11");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule